// File: doc/BRIEF.md
# Isochronous Endpoint Capture DMA

This block carries audio samples from a codec-side sample stream into one of two endpoint buffers, X and Y, held in a shared byte-wide buffer RAM. It works one USB frame at a time. Throughout a frame, every accepted sample is written into the active buffer as 1 to 4 bytes, least significant byte first. Each buffer has its own base address and its own size.

When a start-of-frame pulse arrives, the block writes the finished buffer's data count byte. Its sample count sits in bits 6:0 and its NACK flag in bit 7 is cleared to 0, which hands the packet to the USB transmit side. The block then switches to the other buffer and restarts its write pointer at that buffer's base address. A sample that does not fit is dropped, and the block raises a one-cycle request to set the endpoint's overflow bit. Isochronous endpoints raise no interrupt, so the block has no interrupt output.

Configuration comes from the endpoint's register set. The block is idle unless both the enable and the isochronous bits are 1.

Top module: `iso_capture_dma`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_we`, `cnt_we` and `ovf_set` are 0.
- R2: After the block becomes active (`cfg_enable`=1 and `cfg_iso`=1), the first `sof` only arms it. That `sof` makes buffer X active and produces no count write. Samples that arrive before it are ignored: nothing is written and `ovf_set` stays 0.
- R3: An accepted sample is written as `cfg_bps`+1 bytes. Field value 0 means 1 byte and 3 means 4 bytes. The bytes go out on consecutive cycles at consecutive addresses, starting the cycle after the sample is accepted. Bits 7:0 of `smp_data` come first. The first address is the active buffer's base address plus the number of bytes already accepted in this frame.
- R4: A `sof` while armed makes `cnt_we` 1 for exactly the next cycle. In that cycle `cnt_sel` names the finished buffer (0 = X, 1 = Y), `cnt_byte[7]` (NACK) is 0 and `cnt_byte[6:0]` is the number of samples accepted in that frame. This holds for a frame with no samples too.
- R5: After every count write the active buffer alternates (X then Y then X). The write pointer restarts at the new buffer's base address.
- R6: A sample whose bytes would pass the end of the active buffer is dropped. The end is that buffer's own size in bytes (`cfg_x_size` or `cfg_y_size`). A dropped sample causes no memory write, leaves the count unchanged, and pulses `ovf_set` for one cycle, the cycle after the sample.
- R7: The count saturates at 127. A 128th sample in a frame is dropped and signalled as in R6.
- R8: While `cfg_enable`=0 or `cfg_iso`=0, no new sample write, count write or overflow pulse is started. The block returns to its unarmed state, so the next active `sof` only re-arms and selects X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Endpoint enable bit |
| cfg_iso | input | 1 | Isochronous endpoint bit |
| cfg_bps | input | 2 | Bytes per sample minus one |
| cfg_x_base | input | 8 | X buffer base address |
| cfg_y_base | input | 8 | Y buffer base address |
| cfg_x_size | input | 8 | X buffer size in bytes |
| cfg_y_size | input | 8 | Y buffer size in bytes |
| sof | input | 1 | Start-of-frame pulse |
| smp_valid | input | 1 | Sample present on `smp_data` this cycle |
| smp_data | input | 32 | Sample, least significant byte first |
| mem_we | output | 1 | Buffer RAM byte write strobe |
| mem_addr | output | 8 | Buffer RAM byte address |
| mem_wdata | output | 8 | Buffer RAM write byte |
| cnt_we | output | 1 | Data count byte write strobe |
| cnt_sel | output | 1 | Buffer whose count byte is written (0 = X, 1 = Y) |
| cnt_byte | output | 8 | Data count byte: bit 7 NACK (written 0), bits 6:0 sample count |
| ovf_set | output | 1 | Request to set the endpoint overflow bit |

## Verification
Every result is registered once, so each one is due a fixed number of cycles after its stimulus:
- The first byte of a sample is on the write port in the cycle after the sample is accepted, and byte k follows k cycles later.
- The count write appears in the cycle after `sof`.
- The overflow pulse appears in the cycle after the rejected sample.

The bench drives inputs just after a rising edge and checks these outputs just after the edge that registers them. A bench memory model latches writes at the edge that ends each write cycle, and samples are spaced at least five cycles apart, so every burst has finished before the buffer contents are compared.

// File: rtl/iso_dma_pkg.sv
package iso_dma_pkg;

    typedef enum logic {
        BUF_X = 1'b0,
        BUF_Y = 1'b1
    } buf_sel_e;

    function automatic buf_sel_e other_buf(input buf_sel_e b);
        return (b == BUF_X) ? BUF_Y : BUF_X;
    endfunction

endpackage

// File: rtl/iso_dma_fit.sv
module iso_dma_fit #(
    parameter int SIZE_W = 8,
    parameter int CNT_W  = 7,
    parameter int NB_W   = 3
) (
    input  logic [SIZE_W:0]   off,
    input  logic [SIZE_W-1:0] size,
    input  logic [NB_W-1:0]   nbytes,
    input  logic [CNT_W-1:0]  cnt,
    output logic              fits
);
    logic [SIZE_W:0] end_off;

    always_comb begin
        end_off = off + (SIZE_W+1)'(nbytes);
        fits    = (end_off <= {1'b0, size}) && (cnt != {CNT_W{1'b1}});
    end
endmodule

// File: rtl/iso_dma_ser.sv
module iso_dma_ser #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NB_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [NB_W-1:0]   ld_nbytes,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic [DATA_W-1:0] shreg;
        logic [NB_W-1:0]   left;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (load) begin
            s_d.we    = 1'b1;
            s_d.addr  = ld_addr;
            s_d.wdata = ld_data[7:0];
            s_d.shreg = ld_data >> 8;
            s_d.left  = ld_nbytes - NB_W'(1);
        end else if (s_q.left != '0) begin
            s_d.we    = 1'b1;
            s_d.addr  = s_q.addr + ADDR_W'(1);
            s_d.wdata = s_q.shreg[7:0];
            s_d.shreg = s_q.shreg >> 8;
            s_d.left  = s_q.left - NB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign we    = s_q.we;
    assign addr  = s_q.addr;
    assign wdata = s_q.wdata;
endmodule

// File: rtl/iso_capture_dma.sv
module iso_capture_dma
    import iso_dma_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7,
    localparam int BPS_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_iso,
    input  logic [BPS_W-1:0]  cfg_bps,
    input  logic [ADDR_W-1:0] cfg_x_base,
    input  logic [ADDR_W-1:0] cfg_y_base,
    input  logic [SIZE_W-1:0] cfg_x_size,
    input  logic [SIZE_W-1:0] cfg_y_size,
    input  logic              sof,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              cnt_we,
    output logic              cnt_sel,
    output logic [CNT_W:0]    cnt_byte,
    output logic              ovf_set
);
    localparam int NB_W = BPS_W + 1;

    typedef struct packed {
        logic             run;
        buf_sel_e         sel;
        logic [SIZE_W:0]  off;
        logic [CNT_W-1:0] cnt;
        logic             cnt_we;
        buf_sel_e         cnt_sel;
        logic [CNT_W:0]   cnt_byte;
        logic             ovf;
    } frm_t;

    frm_t f_d, f_q;

    logic              active;
    logic [NB_W-1:0]   nbytes;
    logic [ADDR_W-1:0] act_base;
    logic [SIZE_W-1:0] act_size;
    logic              fits;
    logic              ld;
    logic [ADDR_W-1:0] ld_addr;

    assign active   = cfg_enable && cfg_iso;
    assign nbytes   = NB_W'(cfg_bps) + NB_W'(1);
    assign act_base = (f_q.sel == BUF_Y) ? cfg_y_base : cfg_x_base;
    assign act_size = (f_q.sel == BUF_Y) ? cfg_y_size : cfg_x_size;

    iso_dma_fit #(
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W),
        .NB_W   (NB_W)
    ) u_fit (
        .off    (f_q.off),
        .size   (act_size),
        .nbytes (nbytes),
        .cnt    (f_q.cnt),
        .fits   (fits)
    );

    always_comb begin
        f_d        = f_q;
        f_d.cnt_we = 1'b0;
        f_d.ovf    = 1'b0;
        ld         = 1'b0;
        ld_addr    = act_base + ADDR_W'(f_q.off);
        if (!active) begin
            f_d.run = 1'b0;
            f_d.sel = BUF_X;
            f_d.off = '0;
            f_d.cnt = '0;
        end else if (sof) begin
            if (f_q.run) begin
                f_d.cnt_we   = 1'b1;
                f_d.cnt_sel  = f_q.sel;
                f_d.cnt_byte = {1'b0, f_q.cnt};
                f_d.sel      = other_buf(f_q.sel);
            end
            f_d.run = 1'b1;
            f_d.off = '0;
            f_d.cnt = '0;
        end else if (smp_valid && f_q.run) begin
            if (fits) begin
                ld      = 1'b1;
                f_d.off = f_q.off + (SIZE_W+1)'(nbytes);
                f_d.cnt = f_q.cnt + CNT_W'(1);
            end else begin
                f_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    iso_dma_ser #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NB_W   (NB_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .ld_addr   (ld_addr),
        .ld_data   (smp_data),
        .ld_nbytes (nbytes),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata)
    );

    assign cnt_we   = f_q.cnt_we;
    assign cnt_sel  = f_q.cnt_sel;
    assign cnt_byte = f_q.cnt_byte;
    assign ovf_set  = f_q.ovf;
endmodule

// File: rtl/iso_dma_chk.sv
module iso_dma_chk #(
    parameter int CNT_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_enable,
    input logic           cfg_iso,
    input logic           sof,
    input logic           smp_valid,
    input logic           mem_we,
    input logic           cnt_we,
    input logic [CNT_W:0] cnt_byte,
    input logic           ovf_set
);
    // R4: the hand-off write always clears NACK
    a_r4_nack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |-> (cnt_byte[CNT_W] == 1'b0));

    // R4: a count write follows a start-of-frame pulse
    a_r4_cnt_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |-> $past(sof));

    // R3: a write burst begins only the cycle after a sample
    a_r3_burst_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |-> $past(smp_valid));

    // R6: an overflow pulse follows a presented sample
    a_r6_ovf_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |-> $past(smp_valid));

    // R8: nothing starts while the endpoint is off
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_enable && cfg_iso) && !mem_we) |=> (!mem_we && !cnt_we && !ovf_set));
endmodule

bind iso_capture_dma iso_dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_iso    (cfg_iso),
    .sof        (sof),
    .smp_valid  (smp_valid),
    .mem_we     (mem_we),
    .cnt_we     (cnt_we),
    .cnt_byte   (cnt_byte),
    .ovf_set    (ovf_set)
);

// File: tb/iso_capture_dma_bench.sv
module iso_capture_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_iso = 1'b0;
    logic [1:0]  cfg_bps = '0;
    logic [7:0]  cfg_x_base = '0, cfg_y_base = '0, cfg_x_size = '0, cfg_y_size = '0;
    logic        sof = 1'b0, smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        mem_we, cnt_we, cnt_sel, ovf_set;
    logic [7:0]  mem_addr, mem_wdata, cnt_byte;

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_cnt = 0, n_ovf = 0;
    logic       last_sel;
    logic [7:0] last_byte;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    iso_capture_dma u_iso_capture_dma (.*);

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                n_wr++;
            end
            if (cnt_we) begin
                n_cnt++;
                last_sel  = cnt_sel;
                last_byte = cnt_byte;
            end
            if (ovf_set) n_ovf++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_sample(input logic [31:0] d);
        smp_valid = 1'b1;
        smp_data  = d;
        tick(1);
        smp_valid = 1'b0;
        tick(4);
    endtask

    task automatic pulse_sof();
        sof = 1'b1;
        tick(1);
        sof = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        tick(2);
        check("R1", "mem_we in reset", mem_we, 0);
        check("R1", "cnt_we in reset", cnt_we, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1", "mem_we after reset", mem_we, 0);
        check("R1", "cnt_we after reset", cnt_we, 0);
        check("R1", "ovf_set after reset", ovf_set, 0);
    endtask

    task automatic t_arm();
        cfg_enable = 1'b1; cfg_iso = 1'b1; cfg_bps = 2'd1;
        cfg_x_base = 8'h10; cfg_y_base = 8'h80;
        cfg_x_size = 8'd16; cfg_y_size = 8'd12;
        tick(1);
        send_sample(32'h1111);
        check("R2", "no write before arming sof", n_wr, 0);
        check("R2", "no overflow before arming", n_ovf, 0);
        pulse_sof();
        check("R2", "arming sof gives no count write", n_cnt, 0);
    endtask

    task automatic t_frame_x();
        smp_valid = 1'b1; smp_data = 32'h0000A1B2;
        tick(1);
        smp_valid = 1'b0;
        check("R3", "byte0 strobe", mem_we, 1);
        check("R3", "byte0 address", mem_addr, 8'h10);
        check("R3", "byte0 data", mem_wdata, 8'hB2);
        tick(1);
        check("R3", "byte1 address", mem_addr, 8'h11);
        check("R3", "byte1 data", mem_wdata, 8'hA1);
        tick(1);
        check("R3", "burst ends after 2 bytes", mem_we, 0);
        tick(3);
        send_sample(32'h0304);
        send_sample(32'h0506);
        sof = 1'b1;
        tick(1);
        sof = 1'b0;
        check("R4", "cnt_we after sof", cnt_we, 1);
        check("R4", "cnt_sel is X", cnt_sel, 0);
        check("R4", "count byte X", cnt_byte, 8'h03);
        tick(1);
        check("R4", "cnt_we single cycle", cnt_we, 0);
        check("R3", "mem 0x12", mem[8'h12], 8'h04);
        check("R3", "mem 0x13", mem[8'h13], 8'h03);
        check("R3", "mem 0x15", mem[8'h15], 8'h05);
        check("R3", "mem 0x16 untouched", mem[8'h16], 8'hEE);
    endtask

    task automatic t_frame_y_ovf();
        cfg_bps = 2'd3;
        send_sample(32'h11223344);
        send_sample(32'h55667788);
        send_sample(32'h99AABBCC);
        smp_valid = 1'b1; smp_data = 32'hDEADBEEF;
        tick(1);
        smp_valid = 1'b0;
        check("R6", "ovf_set pulse", ovf_set, 1);
        check("R6", "no write on dropped sample", mem_we, 0);
        tick(1);
        check("R6", "ovf_set one cycle", ovf_set, 0);
        tick(3);
        check("R5", "Y base byte", mem[8'h80], 8'h44);
        check("R3", "Y 4-byte top", mem[8'h83], 8'h11);
        check("R6", "last fitting byte", mem[8'h8B], 8'h99);
        check("R6", "past Y end untouched", mem[8'h8C], 8'hEE);
        pulse_sof();
        check("R4", "Y count sel", last_sel, 1);
        check("R6", "Y count excludes drop", last_byte, 8'h03);
        for (int i = 0; i < 5; i++) send_sample(32'hC0C1C2C3 + i);
        check("R5", "X restarts at base", mem[8'h10], 8'hC3);
        check("R6", "X own size 16 holds 4", mem[8'h1C], 8'hC6);
        check("R6", "beyond X end untouched", mem[8'h20], 8'hEE);
        check("R6", "overflow total", n_ovf, 2);
        pulse_sof();
        check("R5", "back to X sel", last_sel, 0);
        check("R4", "X count 4", last_byte, 8'h04);
    endtask

    task automatic t_empty();
        pulse_sof();
        check("R4", "empty frame sel Y", last_sel, 1);
        check("R4", "empty frame count 0", last_byte, 8'h00);
    endtask

    task automatic t_inactive();
        int wr0, cnt0;
        wr0 = n_wr; cnt0 = n_cnt;
        cfg_iso = 1'b0;
        send_sample(32'h77);
        pulse_sof();
        cfg_iso = 1'b1; cfg_enable = 1'b0;
        send_sample(32'h78);
        pulse_sof();
        check("R8", "no writes while off", n_wr, wr0);
        check("R8", "no count writes while off", n_cnt, cnt0);
        check("R8", "no overflow while off", n_ovf, 2);
        cfg_enable = 1'b1; cfg_bps = 2'd0;
        pulse_sof();
        check("R8", "re-enable sof only arms", n_cnt, cnt0);
        send_sample(32'h5A);
        check("R8", "re-armed into X base", mem[8'h10], 8'h5A);
        pulse_sof();
        check("R8", "re-armed count sel X", last_sel, 0);
        check("R8", "re-armed count 1", last_byte, 8'h01);
    endtask

    task automatic t_limit();
        cfg_y_base = 8'h00; cfg_y_size = 8'hFF;
        for (int i = 0; i < 130; i++) send_sample(32'(i));
        check("R7", "byte 126 written", mem[8'h7E], 8'd126);
        check("R7", "byte 127 not written", mem[8'h7F], 8'hEE);
        check("R7", "overflow on 128th+", n_ovf, 5);
        pulse_sof();
        check("R7", "count saturates", last_byte, 8'h7F);
        check("R7", "limit frame sel Y", last_sel, 1);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        tick(200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_arm();
        t_frame_x();
        t_frame_y_ovf();
        t_empty();
        t_inactive();
        t_limit();
        finish_up();
    end
endmodule